// File: doc/BRIEF.md
# Bank Set Search Sequencer

This block finds a cache line within one bank set of a cache whose lines can move between banks. A bank set is a group of banks that serve as the ways of a single set. Each bank holds one way, and the banks are numbered by their distance from the controller: bank 0 is the closest. For each lookup request the sequencer sends one-cycle probe strobes to the banks. It waits a fixed number of cycles for each probed bank to return its full-tag hit indication. It then reports either a hit, with the way number, or a miss.

Four search orders are available per request:

- serial, one bank at a time from the nearest;
- broadcast to every candidate bank at once;
- a hybrid that probes the nearest banks together and then continues serially;
- a grouped order that probes fixed groups of consecutive banks one group after another.

An optional filter compares a short partial tag held by the controller for each way against the partial tag of the request. Banks that cannot match are never probed. Banks that pass the filter but miss on the full tag are counted as false hits.

The bank arrays are outside the block. They are represented by the per-bank hit inputs, and returning the data is not part of this block.

Top module: `bank_set_search`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `doneValid` is 0 and no probe strobe is driven.
- R2: A request is accepted when `reqValid` is 1 while the block is idle. When `reqFilter` is 1, the candidate banks are those whose partial tag (bits `[i*PTAG_W +: PTAG_W]` of `wayPtags`) equals `reqPtag`. When `reqFilter` is 0, every bank is a candidate. No bank outside the candidate set is ever strobed.
- R3: If the candidate set is empty, `doneValid` rises in the cycle after acceptance with `doneHit` 0, and no bank is probed.
- R4: With policy code 0 (serial), each round strobes only the nearest candidate bank not yet probed.
- R5: With policy code 1 (broadcast), a single round strobes all candidate banks together.
- R6: With policy code 2 (hybrid), the first round strobes together all candidates among banks 0 to LIMIT_M-1. Every later round strobes one bank, nearest first. If no candidate lies among the first LIMIT_M banks, the search is serial from the start.
- R7: With policy code 3 (grouped), the banks form groups of PART_SIZE consecutive banks. Each round strobes all unprobed candidates in the nearest group that still has one.
- R8: A strobe in cycle t is answered by `bankHit` in cycle t+PROBE_LAT. The next round strobes in the following cycle. `doneValid` is a single-cycle pulse one cycle after the deciding response. A lookup of r rounds therefore reports 1+r*(1+PROBE_LAT) cycles after acceptance.
- R9: When a round returns a hit, the search stops. `doneHit` is 1 and `doneWay` is the nearest hitting bank of that round.
- R10: When every candidate has been probed without a hit, the block reports a miss (`doneHit` 0).
- R11: With the filter on, `doneFalseHits` equals the number of probed banks that returned no hit. With the filter off it is 0.
- R12: `reqValid` has no effect while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request |
| reqPolicy | input | 2 | Search order: 0 serial, 1 broadcast, 2 hybrid, 3 grouped |
| reqFilter | input | 1 | Enable partial-tag filtering |
| reqPtag | input | PTAG_W | Partial tag of the requested address |
| wayPtags | input | NUM_WAYS*PTAG_W | Stored partial tag per way, way i at bits i*PTAG_W |
| bankHit | input | NUM_WAYS | Full-tag hit per bank, valid PROBE_LAT cycles after its strobe |
| probeStrobe | output | NUM_WAYS | One-cycle probe strobe per bank |
| busy | output | 1 | A lookup is in progress |
| doneValid | output | 1 | Result pulse |
| doneHit | output | 1 | Line found |
| doneWay | output | $clog2(NUM_WAYS) | Way where the line was found |
| doneFalseHits | output | $clog2(NUM_WAYS+1) | Filter-passing banks that missed |

## Verification
The bench sweeps all 16 partial-tag match patterns with the filter on and off, under each of the four policies. Each combination is run with the line absent and with the line present in each of the four banks, including banks the filter rejects.

The line placed in every bank position separates the orders by their round sequence and completion cycle. The absent and rejected cases exercise miss exhaustion and the empty-candidate shortcut. The bank model drives the inverse of the true answer in every cycle except the exact response cycle, so a response sampled too early or too late produces a wrong result.

Each lookup also injects a conflicting request one cycle after acceptance. This shows that requests arriving while busy are ignored.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    POL_SERIAL = 2'd0,
    POL_BCAST  = 2'd1,
    POL_HYBRID = 2'd2,
    POL_GROUP  = 2'd3
  } policy_e;

  typedef struct packed {
    logic load;
    logic issue;
    logic sample;
  } seqCtrl_t;
endpackage

// File: rtl/bss_datapath.sv
module bss_datapath
  import bss_pkg::*;
#(
  parameter int NUM_WAYS  = 4,
  parameter int PTAG_W    = 4,
  parameter int LIMIT_M   = 2,
  parameter int PART_SIZE = 2,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int FH_W     = $clog2(NUM_WAYS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqCtrl_t                   ctrl,
  input  logic [1:0]                 reqPolicy,
  input  logic                       reqFilter,
  input  logic [PTAG_W-1:0]          reqPtag,
  input  logic [NUM_WAYS*PTAG_W-1:0] wayPtags,
  input  logic [NUM_WAYS-1:0]        bankHit,
  output logic [NUM_WAYS-1:0]        probeStrobe,
  output logic                       candEmpty,
  output logic                       groupHit,
  output logic                       remainEmpty,
  output logic                       resHit,
  output logic [WAY_W-1:0]           resWay,
  output logic [FH_W-1:0]            resFalse
);
  localparam int NUM_PARTS = NUM_WAYS / PART_SIZE;
  localparam logic [NUM_WAYS-1:0] LOW_MASK  = NUM_WAYS'((1 << LIMIT_M) - 1);
  localparam logic [NUM_WAYS-1:0] PART_BASE = NUM_WAYS'((1 << PART_SIZE) - 1);

  logic [NUM_WAYS-1:0] ptagMatch;
  logic [NUM_WAYS-1:0] candNow;
  logic [NUM_WAYS-1:0] remQ;
  logic [NUM_WAYS-1:0] groupQ;
  logic [NUM_WAYS-1:0] groupSel;
  logic [NUM_WAYS-1:0] lowestRem;
  logic [NUM_WAYS-1:0] hitVec;
  logic                firstQ;
  logic                filterQ;
  policy_e             policyQ;

  function automatic logic [FH_W-1:0] popCount(input logic [NUM_WAYS-1:0] v);
    logic [FH_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_WAYS; i++) n = n + FH_W'(v[i]);
    return n;
  endfunction

  function automatic logic [WAY_W-1:0] nearestIdx(input logic [NUM_WAYS-1:0] v);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) if (v[i]) idx = WAY_W'(i);
    return idx;
  endfunction

  // Partial-tag compare, one comparator per way
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_ptag
    assign ptagMatch[g] = (wayPtags[g*PTAG_W +: PTAG_W] == reqPtag);
  end

  assign candNow   = reqFilter ? ptagMatch : '1;
  assign candEmpty = (candNow == '0);
  assign lowestRem = remQ & (~remQ + NUM_WAYS'(1));

  // Group chosen for the next round
  always_comb begin
    logic found;
    found    = 1'b0;
    groupSel = '0;
    unique case (policyQ)
      POL_SERIAL: groupSel = lowestRem;
      POL_BCAST:  groupSel = remQ;
      POL_HYBRID: groupSel = (firstQ && |(remQ & LOW_MASK)) ? (remQ & LOW_MASK) : lowestRem;
      POL_GROUP: begin
        for (int p = 0; p < NUM_PARTS; p++) begin
          if (!found && |(remQ & (PART_BASE << (p * PART_SIZE)))) begin
            groupSel = remQ & (PART_BASE << (p * PART_SIZE));
            found    = 1'b1;
          end
        end
      end
      default: groupSel = lowestRem;
    endcase
  end

  assign probeStrobe = ctrl.issue ? groupSel : '0;
  assign hitVec      = bankHit & groupQ;
  assign groupHit    = |hitVec;
  assign remainEmpty = (remQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ     <= '0;
      groupQ   <= '0;
      firstQ   <= 1'b0;
      filterQ  <= 1'b0;
      policyQ  <= POL_SERIAL;
      resHit   <= 1'b0;
      resWay   <= '0;
      resFalse <= '0;
    end else begin
      if (ctrl.load) begin
        remQ     <= candNow;
        firstQ   <= 1'b1;
        filterQ  <= reqFilter;
        policyQ  <= policy_e'(reqPolicy);
        resHit   <= 1'b0;
        resWay   <= '0;
        resFalse <= '0;
      end
      if (ctrl.issue) begin
        remQ   <= remQ & ~groupSel;
        groupQ <= groupSel;
        firstQ <= 1'b0;
      end
      if (ctrl.sample) begin
        if (groupHit) begin
          resHit <= 1'b1;
          resWay <= nearestIdx(hitVec);
          if (filterQ) resFalse <= resFalse + popCount(groupQ & ~hitVec);
        end else if (filterQ) begin
          resFalse <= resFalse + popCount(groupQ);
        end
      end
    end
  end

  // R4: serial order never strobes more than one bank at a time
  p_serial_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (policyQ == POL_SERIAL) |-> $onehot0(probeStrobe));

  // R10: a round is only started when a candidate is left to probe
  p_issue_nonempty_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.issue |-> (probeStrobe != '0));

  // R8: strobes are separated by the response wait
  p_strobe_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|probeStrobe) |=> (probeStrobe == '0));
endmodule

// File: rtl/bss_ctrl.sv
module bss_ctrl
  import bss_pkg::*;
#(
  parameter int PROBE_LAT = 2,
  localparam int CNT_W    = $clog2(PROBE_LAT + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     candEmpty,
  input  logic     groupHit,
  input  logic     remainEmpty,
  output seqCtrl_t ctrl,
  output logic     busy,
  output logic     doneValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_e;

  state_e          stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic            respNow;

  assign respNow = (cntQ == CNT_W'(PROBE_LAT));

  always_comb begin
    ctrl   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.load = 1'b1;
          stateD    = candEmpty ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        ctrl.issue = 1'b1;
        stateD     = ST_WAIT;
      end
      ST_WAIT: begin
        if (respNow) begin
          ctrl.sample = 1'b1;
          stateD      = (groupHit || remainEmpty) ? ST_DONE : ST_ISSUE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_ISSUE) cntQ <= CNT_W'(1);
      else if (stateQ == ST_WAIT && !respNow) cntQ <= cntQ + CNT_W'(1);
    end
  end

  assign busy      = (stateQ != ST_IDLE);
  assign doneValid = (stateQ == ST_DONE);

  // R8: result is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R3: nothing to probe gives an answer on the next cycle
  p_empty_fast_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && candEmpty) |=> doneValid);

  // R12: while a lookup runs, a new request does not restart it
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneValid) |=> busy);
endmodule

// File: rtl/bank_set_search.sv
module bank_set_search
  import bss_pkg::*;
#(
  parameter int NUM_WAYS  = 4,
  parameter int PTAG_W    = 4,
  parameter int PROBE_LAT = 2,
  parameter int LIMIT_M   = 2,
  parameter int PART_SIZE = 2,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int FH_W     = $clog2(NUM_WAYS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [1:0]                 reqPolicy,
  input  logic                       reqFilter,
  input  logic [PTAG_W-1:0]          reqPtag,
  input  logic [NUM_WAYS*PTAG_W-1:0] wayPtags,
  input  logic [NUM_WAYS-1:0]        bankHit,
  output logic [NUM_WAYS-1:0]        probeStrobe,
  output logic                       busy,
  output logic                       doneValid,
  output logic                       doneHit,
  output logic [WAY_W-1:0]           doneWay,
  output logic [FH_W-1:0]            doneFalseHits
);
  seqCtrl_t ctrl;
  logic     candEmpty;
  logic     groupHit;
  logic     remainEmpty;

  bss_ctrl #(.PROBE_LAT(PROBE_LAT)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .candEmpty(candEmpty),
    .groupHit(groupHit), .remainEmpty(remainEmpty), .ctrl(ctrl),
    .busy(busy), .doneValid(doneValid)
  );

  bss_datapath #(
    .NUM_WAYS(NUM_WAYS), .PTAG_W(PTAG_W), .LIMIT_M(LIMIT_M), .PART_SIZE(PART_SIZE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqPolicy(reqPolicy),
    .reqFilter(reqFilter), .reqPtag(reqPtag), .wayPtags(wayPtags),
    .bankHit(bankHit), .probeStrobe(probeStrobe), .candEmpty(candEmpty),
    .groupHit(groupHit), .remainEmpty(remainEmpty), .resHit(doneHit),
    .resWay(doneWay), .resFalse(doneFalseHits)
  );
endmodule

// File: tb/test_bank_set_search.sv
module test_bank_set_search;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4, PW = 4, LAT = 2, LM = 2, PS = 2;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqFilter;
  logic [1:0] reqPolicy;
  logic [PW-1:0] reqPtag;
  logic [NW*PW-1:0] wayPtags;
  logic [NW-1:0] bankHit, probeStrobe, present;
  logic busy, doneValid, doneHit;
  logic [1:0] doneWay;
  logic [2:0] doneFalseHits;
  logic [NW-1:0] dly [LAT];

  int checks = 0, failures = 0;
  logic [NW-1:0] expGroups [NW];
  int expRounds, expWay, expFalse, expCycles;
  bit expHit;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_set_search #(.NUM_WAYS(NW), .PTAG_W(PW), .PROBE_LAT(LAT), .LIMIT_M(LM), .PART_SIZE(PS))
    i_bank_set_search (
      .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPolicy(reqPolicy),
      .reqFilter(reqFilter), .reqPtag(reqPtag), .wayPtags(wayPtags),
      .bankHit(bankHit), .probeStrobe(probeStrobe), .busy(busy),
      .doneValid(doneValid), .doneHit(doneHit), .doneWay(doneWay),
      .doneFalseHits(doneFalseHits));

  // Bank model: true answer only in the response cycle, inverted otherwise
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) dly[i] <= '0;
    end else begin
      dly[0] <= probeStrobe;
      for (int i = 1; i < LAT; i++) dly[i] <= dly[i-1];
    end
  end
  assign bankHit = (dly[LAT-1] & present) | (~dly[LAT-1] & ~present);

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pop(input logic [NW-1:0] v);
    int n = 0;
    for (int i = 0; i < NW; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [NW-1:0] pickGroup(input int pol, input logic [NW-1:0] rem, input bit first);
    logic [NW-1:0] low;
    logic [NW-1:0] lowBanks;
    low = '0;
    for (int i = NW - 1; i >= 0; i--) if (rem[i]) low = NW'(1) << i;
    lowBanks = NW'((1 << LM) - 1);
    case (pol)
      0: return low;
      1: return rem;
      2: return (first && (rem & lowBanks) != 0) ? (rem & lowBanks) : low;
      default: begin
        for (int p = 0; p < NW / PS; p++) begin
          logic [NW-1:0] pm;
          pm = NW'((1 << PS) - 1) << (p * PS);
          if ((rem & pm) != 0) return rem & pm;
        end
        return '0;
      end
    endcase
  endfunction

  function automatic string polTag(input int pol);
    case (pol)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic predict(input int pol, input bit filt, input logic [NW-1:0] m, input logic [NW-1:0] pres);
    logic [NW-1:0] rem, grp, hv;
    bit first;
    rem = filt ? m : '1;
    first = 1'b1;
    expRounds = 0; expHit = 1'b0; expWay = 0; expFalse = 0;
    for (int i = 0; i < NW; i++) expGroups[i] = '0;
    while (rem != 0 && !expHit) begin
      grp = pickGroup(pol, rem, first);
      first = 1'b0;
      expGroups[expRounds] = grp;
      expRounds++;
      rem &= ~grp;
      hv = grp & pres;
      if (hv != 0) begin
        expHit = 1'b1;
        for (int i = NW - 1; i >= 0; i--) if (hv[i]) expWay = i;
        if (filt) expFalse += pop(grp & ~hv);
      end else if (filt) begin
        expFalse += pop(grp);
      end
    end
    expCycles = 1 + expRounds * (1 + LAT);
  endtask

  task automatic runOne(input int pol, input bit filt, input logic [NW-1:0] m, input logic [NW-1:0] pres);
    int k, rnd;
    bit done;
    logic [NW-1:0] cand;
    predict(pol, filt, m, pres);
    cand = filt ? m : '1;
    @(negedge clk);
    present = pres;
    reqPtag = 4'h5;
    for (int i = 0; i < NW; i++) wayPtags[i*PW +: PW] = m[i] ? 4'h5 : 4'hD;
    reqPolicy = 2'(pol); reqFilter = filt; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // Conflicting request while busy (R12)
    reqPolicy = 2'(pol ^ 1); reqFilter = ~filt; reqPtag = 4'hD;
    k = 1; rnd = 0; done = 1'b0;
    while (!done && k <= 60) begin
      if (probeStrobe != 0) begin
        check((probeStrobe & ~cand) == 0, "R2", "strobe outside candidates", int'(probeStrobe), int'(cand));
        check(rnd < expRounds && probeStrobe == expGroups[rnd % NW], polTag(pol), "round group",
              int'(probeStrobe), int'(expGroups[rnd % NW]));
        rnd++;
      end
      if (doneValid) done = 1'b1;
      else begin
        @(posedge clk);
        @(negedge clk);
        reqValid = 1'b0;
        k++;
      end
    end
    reqValid = 1'b0;
    check(done, "R8", "watchdog result seen", int'(done), 1);
    check(k == expCycles, (cand == 0) ? "R3" : "R8", "result cycle", k, expCycles);
    check(rnd == expRounds, "R12", "rounds unaffected by busy request", rnd, expRounds);
    check(doneHit == expHit, expHit ? "R9" : "R10", "hit flag", int'(doneHit), int'(expHit));
    if (expHit) check(int'(doneWay) == expWay, "R9", "way", int'(doneWay), expWay);
    check(int'(doneFalseHits) == expFalse, "R11", "false hits", int'(doneFalseHits), expFalse);
    @(negedge clk);
    check(!doneValid && !busy, "R8", "pulse ended and idle", int'(doneValid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R8 global watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqPolicy = '0; reqFilter = 1'b0;
    reqPtag = '0; wayPtags = '0; present = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !doneValid && probeStrobe == 0, "R1", "reset idle", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !doneValid && probeStrobe == 0, "R1", "idle after reset release", int'(probeStrobe), 0);
    for (int pol = 0; pol < 4; pol++)
      for (int filt = 0; filt < 2; filt++)
        for (int m = 0; m < 16; m++)
          for (int p = 0; p <= NW; p++)
            runOne(pol, filt[0], 4'(m), (p == 0) ? 4'b0 : 4'(1 << (p - 1)));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule